// File: doc/BRIEF.md
# Secure Real-Time Clock Register Block

This block is a memory-mapped timekeeping peripheral. It keeps a 32-bit whole-seconds count and a sub-second fraction. The fraction advances on an external tick strobe and carries into the seconds count when it wraps at a parameterised modulus. A 64-bit alarm comparator raises a sticky flag when the time value equals the programmed alarm. A status register reports the write handshake, the alarm, and a power-on "time not trusted" condition. One level interrupt output is the OR of the enabled status flags.

Every register write from the bus is committed to the core through a fixed-latency handshake of `COMMIT_LAT` cycles (default 4). While a commit is in flight, any new bus write is discarded and flagged as an error. Software waits for the completion flag or the error flag before it issues the next write. After reset the counter does not run. It advances only when the run bit is set and the seconds register has been written at least once. The untrusted flag stays set until software clears it explicitly.

Word map (3-bit address): 0 seconds, 1 fraction, 2 alarm upper word, 3 alarm lower word, 4 control, 5 status, 6 interrupt enable. Address 7 reads zero and ignores writes. In the control register, bit 3 is the run bit. In the status register: bit 10 busy, bit 9 ready-for-next, bit 8 write done, bit 7 write error, bit 4 alarm, bit 1 untrusted, bit 0 violation (always reads 0 here).

Top module: `sec_rtc`

## Requirements
- R1: After reset, status reads 0x202 (ready-for-next and untrusted), control reads 0, interrupt enable reads 0, alarm upper reads 0xFFFFFFFF, alarm lower, seconds and fraction read 0, and `irq` is low.
- R2: The block accepts a bus write when it is not busy. Status bit 10 then reads 1 for exactly `COMMIT_LAT` cycles after the accepting edge. The target register keeps its old value until the last of those edges. At that edge the new value appears and status bit 8 (write done) is set.
- R3: A bus write that arrives while busy is dropped: the register it addresses is unchanged. Status bit 7 (write error) is set on that edge.
- R4: A committed write to status clears each of bits 8, 7 and 4 whose data bit is 1. A committed status write with data bit 8 set leaves bit 8 clear. Any other committed write sets bit 8.
- R5: Status bit 1 (untrusted) clears only when a committed status write carries 1 in both bit 1 and bit 0. Bit 1 alone leaves it set.
- R6: The counter does not advance, even with control bit 3 set and ticks present, until seconds has been written once after reset.
- R7: Once seconds has been written, each tick with control bit 3 set increments the fraction. A tick at fraction `FRAC_MOD-1` wraps the fraction to 0 and increments seconds. With bit 3 clear, ticks have no effect.
- R8: Writing the fraction and then the seconds sets the time exactly. When a time-register commit coincides with a tick, the written value is loaded and the tick is lost.
- R9: When the alarm upper word is not 0xFFFFFFFF and {seconds, fraction} equals {alarm upper, alarm lower}, status bit 4 sets on the next edge. With alarm upper at 0xFFFFFFFF it never sets.
- R10: `irq` is high exactly while some status bit among 9, 8, 7 and 4 is 1 together with the same bit of interrupt enable. Bit 9 reads 1 whenever the block is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Sub-second advance strobe, one cycle per step |
| bus_wr | input | 1 | Register write request |
| bus_addr | input | 3 | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt, OR of enabled flags |

## Verification
Corrupt handshake state shows up on the very next sample. A stuck or short busy count changes how long status bit 10 stays high, or when the written value appears, and a lost error latch leaves bit 7 clear after a dropped write. A wrong counter gate or carry shows as a seconds or fraction value that is off after a known number of ticks. That value can be read back immediately after those ticks. A bad alarm or interrupt term shows one cycle after the matching time or flag, as status bit 4 or `irq` at the wrong level.

// File: rtl/sec_rtc_pkg.sv
// Shared definitions for the secure RTC register block.
// Assumes a 3-bit word address and 32-bit registers.
package sec_rtc_pkg;
    localparam int DW = 32;
    localparam int AW = 3;

    typedef enum logic [AW-1:0] {
        A_SECS   = 3'd0,
        A_FRAC   = 3'd1,
        A_ALM_HI = 3'd2,
        A_ALM_LO = 3'd3,
        A_CTRL   = 3'd4,
        A_STAT   = 3'd5,
        A_IEN    = 3'd6,
        A_NONE   = 3'd7
    } reg_addr_e;

    localparam int CTRL_RUN = 3;
    localparam int ST_BUSY  = 10;
    localparam int ST_NEXT  = 9;
    localparam int ST_DONE  = 8;
    localparam int ST_ERR   = 7;
    localparam int ST_ALM   = 4;
    localparam int ST_NVAL  = 1;
    localparam int ST_VIOL  = 0;

    localparam logic [DW-1:0] IRQ_MASK =
        (DW'(1) << ST_NEXT) | (DW'(1) << ST_DONE) |
        (DW'(1) << ST_ERR)  | (DW'(1) << ST_ALM);
endpackage

// File: rtl/sec_rtc_commit.sv
// Write handshake: captures one bus write, holds it for LAT cycles, then
// emits a one-cycle commit strobe with the captured address and data.
// A write arriving while a commit is in flight is reported as dropped.
// Assumes LAT >= 1.
module sec_rtc_commit
    import sec_rtc_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          busy,
    output logic          drop,
    output logic          cmt_vld,
    output logic [AW-1:0] cmt_addr,
    output logic [DW-1:0] cmt_data
);
    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0] cnt_q;

    // Busy count and captured write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            cmt_addr <= '0;
            cmt_data <= '0;
        end else if (wr_req && !busy) begin
            cnt_q    <= CW'(LAT);
            cmt_addr <= wr_addr;
            cmt_data <= wr_data;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Handshake outputs.
    always_comb begin
        busy    = (cnt_q != '0);
        drop    = wr_req && busy;
        cmt_vld = (cnt_q == CW'(1));
    end

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !busy) |=> (busy && cmt_addr == $past(wr_addr)
                               && cmt_data == $past(wr_data)));
    p_idle_after_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_vld |=> !busy);
    p_hold_while_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cmt_vld) |=> ($stable(cmt_addr) && $stable(cmt_data)));
endmodule

// File: rtl/sec_rtc_time.sv
// Timekeeping core: seconds and fraction counters plus alarm comparison.
// The counter runs only after seconds has been loaded once since reset and
// while run_en is high. A load of either time word takes precedence over a
// tick in the same cycle. Assumes FRAC_MOD >= 2.
module sec_rtc_time
    import sec_rtc_pkg::*;
#(
    parameter int FRAC_MOD = 32768
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          run_en,
    input  logic          ld_secs,
    input  logic          ld_frac,
    input  logic [DW-1:0] ld_data,
    input  logic [DW-1:0] alm_hi,
    input  logic [DW-1:0] alm_lo,
    output logic [DW-1:0] secs,
    output logic [DW-1:0] frac,
    output logic          alm_match
);
    localparam int FW = $clog2(FRAC_MOD);
    localparam logic [FW-1:0] FRAC_TOP = FW'(FRAC_MOD - 1);

    logic [DW-1:0] secs_q;
    logic [FW-1:0] frac_q;
    logic          seen_q;
    logic          step;
    logic          wrap;

    // Advance and wrap conditions.
    always_comb begin
        step = tick && run_en && seen_q && !ld_secs && !ld_frac;
        wrap = (frac_q >= FRAC_TOP);
    end

    // Seconds register and first-load flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            secs_q <= '0;
            seen_q <= 1'b0;
        end else if (ld_secs) begin
            secs_q <= ld_data;
            seen_q <= 1'b1;
        end else if (step && wrap) begin
            secs_q <= secs_q + 1'b1;
        end
    end

    // Fraction register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frac_q <= '0;
        end else if (ld_frac) begin
            frac_q <= ld_data[FW-1:0];
        end else if (step) begin
            frac_q <= wrap ? '0 : frac_q + 1'b1;
        end
    end

    // Output views and alarm match against an armed alarm.
    always_comb begin
        secs      = secs_q;
        frac      = DW'(frac_q);
        alm_match = (alm_hi != '1) && ({secs, frac} == {alm_hi, alm_lo});
    end

    p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_q && !ld_secs && !ld_frac) |=> ($stable(secs_q) && $stable(frac_q)));
    p_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run_en && seen_q && !ld_secs && !ld_frac && frac_q == FRAC_TOP)
        |=> (frac_q == '0 && secs_q == $past(secs_q) + 1'b1));
    p_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !ld_secs && !ld_frac) |=> ($stable(secs_q) && $stable(frac_q)));
    p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_frac |=> (frac_q == $past(ld_data[FW-1:0])));
endmodule

// File: rtl/sec_rtc_status.sv
// Status flags and interrupt combine. Done, error and alarm flags are sticky
// and cleared by writing 1 at commit; the untrusted flag clears only when a
// status commit carries both bit 1 and bit 0. A set condition wins over a
// clear in the same cycle. Assumes at most one commit per cycle.
module sec_rtc_status
    import sec_rtc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic          drop,
    input  logic          cmt_vld,
    input  logic [AW-1:0] cmt_addr,
    input  logic [DW-1:0] cmt_data,
    input  logic          alm_match,
    input  logic [DW-1:0] ien,
    output logic [DW-1:0] stat_word,
    output logic          irq
);
    logic          done_q;
    logic          err_q;
    logic          alm_q;
    logic          nval_q;
    logic          stat_wr;
    logic [DW-1:0] clr;

    // Decode a committed status write into clear requests.
    always_comb begin
        stat_wr = cmt_vld && (cmt_addr == A_STAT);
        clr     = stat_wr ? cmt_data : '0;
    end

    // Sticky flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            alm_q  <= 1'b0;
            nval_q <= 1'b1;
        end else begin
            done_q <= (done_q && !clr[ST_DONE]) ||
                      (cmt_vld && !(stat_wr && cmt_data[ST_DONE]));
            err_q  <= (err_q && !clr[ST_ERR]) || drop;
            alm_q  <= (alm_q && !clr[ST_ALM]) || alm_match;
            if (clr[ST_NVAL] && clr[ST_VIOL]) begin
                nval_q <= 1'b0;
            end
        end
    end

    // Status word assembly and interrupt combine.
    always_comb begin
        stat_word          = '0;
        stat_word[ST_BUSY] = busy;
        stat_word[ST_NEXT] = !busy;
        stat_word[ST_DONE] = done_q;
        stat_word[ST_ERR]  = err_q;
        stat_word[ST_ALM]  = alm_q;
        stat_word[ST_NVAL] = nval_q;
        irq                = |(stat_word & ien & IRQ_MASK);
    end

    p_err_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> err_q);
    p_w1c_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && cmt_data[ST_ERR] && !drop) |=> !err_q);
    p_done_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_vld && !stat_wr) |=> done_q);
    p_nval_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (nval_q && !(stat_wr && cmt_data[ST_NVAL] && cmt_data[ST_VIOL])) |=> nval_q);
    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((ien & IRQ_MASK) == '0) |-> !irq);
endmodule

// File: rtl/sec_rtc.sv
// Secure RTC register block top: bus decode, control/enable/alarm registers,
// commit handshake, timekeeping core and status. All bus writes pass through
// the commit handshake; reads are combinational on bus_addr.
module sec_rtc
    import sec_rtc_pkg::*;
#(
    parameter int FRAC_MOD   = 32768,
    parameter int COMMIT_LAT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          bus_wr,
    input  logic [2:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          irq
);
    logic          busy;
    logic          drop;
    logic          cmt_vld;
    logic [AW-1:0] cmt_addr;
    logic [DW-1:0] cmt_data;
    logic          run_q;
    logic [DW-1:0] ien_q;
    logic [DW-1:0] alm_hi_q;
    logic [DW-1:0] alm_lo_q;
    logic [DW-1:0] secs;
    logic [DW-1:0] frac;
    logic          alm_match;
    logic [DW-1:0] stat_word;
    logic          ld_secs;
    logic          ld_frac;

    sec_rtc_commit #(.LAT(COMMIT_LAT)) u_commit (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (bus_wr),
        .wr_addr  (bus_addr),
        .wr_data  (bus_wdata),
        .busy     (busy),
        .drop     (drop),
        .cmt_vld  (cmt_vld),
        .cmt_addr (cmt_addr),
        .cmt_data (cmt_data)
    );

    // Time-register load strobes from the commit.
    always_comb begin
        ld_secs = cmt_vld && (cmt_addr == A_SECS);
        ld_frac = cmt_vld && (cmt_addr == A_FRAC);
    end

    // Control, enable and alarm registers updated at commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            ien_q    <= '0;
            alm_hi_q <= '1;
            alm_lo_q <= '0;
        end else if (cmt_vld) begin
            case (cmt_addr)
                A_CTRL:   run_q    <= cmt_data[CTRL_RUN];
                A_IEN:    ien_q    <= cmt_data & IRQ_MASK;
                A_ALM_HI: alm_hi_q <= cmt_data;
                A_ALM_LO: alm_lo_q <= cmt_data;
                default:  ;
            endcase
        end
    end

    sec_rtc_time #(.FRAC_MOD(FRAC_MOD)) u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .run_en    (run_q),
        .ld_secs   (ld_secs),
        .ld_frac   (ld_frac),
        .ld_data   (cmt_data),
        .alm_hi    (alm_hi_q),
        .alm_lo    (alm_lo_q),
        .secs      (secs),
        .frac      (frac),
        .alm_match (alm_match)
    );

    sec_rtc_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .drop      (drop),
        .cmt_vld   (cmt_vld),
        .cmt_addr  (cmt_addr),
        .cmt_data  (cmt_data),
        .alm_match (alm_match),
        .ien       (ien_q),
        .stat_word (stat_word),
        .irq       (irq)
    );

    // Read multiplexer.
    always_comb begin
        case (bus_addr)
            A_SECS:   bus_rdata = secs;
            A_FRAC:   bus_rdata = frac;
            A_ALM_HI: bus_rdata = alm_hi_q;
            A_ALM_LO: bus_rdata = alm_lo_q;
            A_CTRL:   bus_rdata = DW'(run_q) << CTRL_RUN;
            A_STAT:   bus_rdata = stat_word;
            A_IEN:    bus_rdata = ien_q;
            default:  bus_rdata = '0;
        endcase
    end

    p_unarmed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_hi_q == '1) |=> !$rose(stat_word[ST_ALM]));
    p_drop_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !cmt_vld) |=> ($stable(ien_q) && $stable(alm_hi_q)
                                && $stable(alm_lo_q) && $stable(run_q)));
endmodule

// File: tb/sec_rtc_tb.sv
module sec_rtc_tb;
    localparam int CLK_P = 10;
    localparam int LAT   = 4;
    localparam int FMOD  = 4;

    localparam logic [2:0] SECS = 0, FRAC = 1, AHI = 2, ALO = 3,
                           CTRL = 4, STAT = 5, IEN = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          n_chk = 0;
    int          n_err = 0;

    sec_rtc #(.FRAC_MOD(FMOD), .COMMIT_LAT(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic chk_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    // Full write: returns after the commit edge.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (LAT) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic t_reset;
        chk("R1 status", 0, 0);
        n_chk--;
        chk_reg("R1 status", STAT, 32'h202);
        chk_reg("R1 ctrl", CTRL, 0);
        chk_reg("R1 ien", IEN, 0);
        chk_reg("R1 alarm hi", AHI, 32'hFFFF_FFFF);
        chk_reg("R1 alarm lo", ALO, 0);
        chk_reg("R1 secs", SECS, 0);
        chk_reg("R1 frac", FRAC, 0);
        chk("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_handshake;
        logic [31:0] v;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = CTRL; bus_wdata = 32'h8;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(STAT, v); chk("R2 busy cycle 1", 32'(v[10]), 1);
        chk_reg("R2 old value while busy", CTRL, 0);
        for (int i = 1; i < LAT; i++) begin
            @(negedge clk);
            rd(STAT, v); chk("R2 busy held", 32'(v[10]), 1);
        end
        @(negedge clk);
        rd(STAT, v); chk("R2 busy dropped", 32'(v[10]), 0);
        chk_reg("R2 committed", CTRL, 32'h8);
        chk_reg("R2 done flag", STAT, 32'h302);
    endtask

    task automatic t_drop;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = IEN; bus_wdata = 32'h10;
        @(negedge clk);
        bus_addr = ALO; bus_wdata = 32'h5;
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (LAT - 1) @(negedge clk);
        chk_reg("R3 dropped target", ALO, 0);
        chk_reg("R3 first write kept", IEN, 32'h10);
        chk_reg("R3 error flag", STAT, 32'h382);
        chk("R3 irq off", 32'(irq), 0);
    endtask

    task automatic t_w1c;
        wr(STAT, 32'h180);
        chk_reg("R4 clear done and error", STAT, 32'h202);
        wr(STAT, 32'h002);
        chk_reg("R5 untrusted kept", STAT, 32'h302);
        wr(STAT, 32'h003);
        chk_reg("R5 untrusted cleared", STAT, 32'h300);
        wr(STAT, 32'h100);
        chk_reg("R4 done cleared", STAT, 32'h200);
    endtask

    task automatic t_count;
        ticks(5);
        chk_reg("R6 secs frozen", SECS, 0);
        chk_reg("R6 frac frozen", FRAC, 0);
        wr(SECS, 100);
        ticks(3);
        chk_reg("R7 frac step", FRAC, 3);
        chk_reg("R7 secs no carry", SECS, 100);
        ticks(1);
        chk_reg("R7 frac wrap", FRAC, 0);
        chk_reg("R7 secs carry", SECS, 101);
        wr(CTRL, 0);
        ticks(3);
        chk_reg("R7 stopped frac", FRAC, 0);
        chk_reg("R7 stopped secs", SECS, 101);
        wr(CTRL, 32'h8);
        ticks(2);
        chk_reg("R7 restarted", FRAC, 2);
    endtask

    task automatic t_settime;
        wr(FRAC, 2);
        wr(SECS, 500);
        chk_reg("R8 secs set", SECS, 500);
        chk_reg("R8 frac set", FRAC, 2);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = FRAC; bus_wdata = 1;
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (2) @(negedge clk);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        chk_reg("R8 load beats tick", FRAC, 1);
        chk_reg("R8 secs kept", SECS, 500);
    endtask

    task automatic t_alarm;
        logic [31:0] v;
        wr(ALO, 3);
        wr(AHI, 500);
        rd(STAT, v); chk("R9 no early alarm", 32'(v[4]), 0);
        ticks(1); @(negedge clk);
        rd(STAT, v); chk("R9 no alarm at frac 2", 32'(v[4]), 0);
        ticks(1); @(negedge clk);
        chk_reg("R9 alarm set", STAT, 32'h310);
        wr(IEN, 32'h10);
        chk("R10 alarm irq", 32'(irq), 1);
        ticks(1);
        wr(STAT, 32'h10);
        rd(STAT, v); chk("R4 alarm cleared", 32'(v[4]), 0);
        chk("R10 irq released", 32'(irq), 0);
        wr(AHI, 32'hFFFF_FFFF);
        wr(ALO, 0);
        wr(FRAC, 0);
        wr(SECS, 32'hFFFF_FFFF);
        @(negedge clk);
        rd(STAT, v); chk("R9 unarmed no alarm", 32'(v[4]), 0);
    endtask

    task automatic t_irq;
        wr(IEN, 32'h100);
        chk("R10 done irq", 32'(irq), 1);
        wr(IEN, 32'h200);
        chk("R10 ready irq idle", 32'(irq), 1);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = STAT; bus_wdata = 32'h100;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R10 ready irq busy", 32'(irq), 0);
        repeat (LAT) @(negedge clk);
        chk("R10 ready irq back", 32'(irq), 1);
        wr(IEN, 0);
        chk("R10 irq masked", 32'(irq), 0);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_handshake();
        t_drop();
        t_w1c();
        t_count();
        t_settime();
        t_alarm();
        t_irq();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule